// File: doc/BRIEF.md
# Hit-Filtered Line Buffer in Front of a First-Level Cache

This block is a small direct-mapped line buffer between a processor and an existing first-level cache. Its purpose is to cut the number of cache accesses. Every processor read looks in the buffer first. A buffer hit is answered without touching the cache. A buffer miss goes to the cache. A line is copied into the buffer only when the cache reports a hit. On a cache miss, the line is fetched from main memory and written into the cache alone. The data then comes back through a second cache read, and the buffer is left as it was. Lines that are touched only once therefore never displace useful buffer lines.

Writes always pass through to the cache. When a write hits the buffer, the buffered copy of that word is updated as well. A write never allocates a buffer line. Only one processor request is in flight at a time. The block outputs one pulse per read outcome, so that a testbench can follow how each read was routed.

Top module: `l0_filter_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, no event pulse is high, and every buffer line is invalid, so the first read of any address goes to the cache.
- R2: A read that hits the buffer raises rsp_valid with the buffered word one cycle after the request is accepted. It raises ev_buf_hit in that same cycle and issues no cache request.
- R3: A read that misses the buffer and hits the cache returns the word the cache supplies and raises ev_l1_hit. It also loads the whole line into the buffer, so a later read of any word in that line is a buffer hit. The address is a word address: bits [1:0] select the word, bits [4:2] the buffer line and bits [31:5] form the tag.
- R4: A read that misses both the buffer and the cache raises ev_l1_miss. It then fetches the line from memory at the line-aligned address, writes the line into the cache, and returns the word from a second cache read. The buffer is not changed, so the next read of that address goes to the cache.
- R5: A line loaded after a cache hit replaces whatever line occupies the same buffer index, and the displaced line then misses the buffer.
- R6: A write is sent to the cache as a single word write. The response comes after the cache acknowledges. If the word is buffered, the buffered copy takes the new value. A write to an unbuffered address allocates nothing.
- R7: req_ready stays 0 from the acceptance of any request that needs the cache until its response has been issued.
- R8: A cache request holds l1_req_valid, l1_op and l1_addr steady until l1_ack. The l1_op codes are 0 for read, 1 for word write and 2 for line fill, and a fill uses a line-aligned address (bits [1:0] zero).
- R9: At most one of ev_buf_hit, ev_l1_hit and ev_l1_miss is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| l1_req_valid | output | 1 | Cache request valid |
| l1_op | output | 2 | Cache operation: 0 read, 1 word write, 2 line fill |
| l1_addr | output | 32 | Cache word address (line-aligned for fill) |
| l1_wdata | output | 32 | Word for cache write |
| l1_wline | output | 128 | Line for cache fill |
| l1_ack | input | 1 | Cache operation done |
| l1_hit | input | 1 | Cache read or write found the line |
| l1_rline | input | 128 | Line returned by a cache read |
| mem_req_valid | output | 1 | Memory line read request |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_ack | input | 1 | Memory line returned |
| mem_rline | input | 128 | Line from memory |
| ev_buf_hit | output | 1 | Pulse: read served by the buffer |
| ev_l1_hit | output | 1 | Pulse: read served by a cache hit |
| ev_l1_miss | output | 1 | Pulse: read missed the cache |

## Verification
The assertions watch the parts of the protocol and routing that every cycle can show. A buffer hit must occur while the cache port is idle. Cache requests must stay stable until acknowledged, and fills and memory requests must use line-aligned addresses. A memory fetch must start only together with a miss pulse, and the outcome pulses must stay exclusive. The directed scenarios are needed for the behaviours that depend on history. These are allocation only after a cache hit, the unchanged buffer after a miss, replacement at a shared index, buffered copies tracking writes, and returned data matching the memory contents.

// File: rtl/l0b_pkg.sv
package l0b_pkg;
  typedef enum logic [1:0] {
    L1_OP_RD   = 2'd0,
    L1_OP_WR   = 2'd1,
    L1_OP_FILL = 2'd2
  } l1_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOK   = 3'd1,
    ST_MEM    = 3'd2,
    ST_FILL   = 3'd3,
    ST_REREAD = 3'd4,
    ST_WRITE  = 3'd5
  } state_e;
endpackage

// File: rtl/l0b_rst_sync.sv
module l0b_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/l0b_tag_array.sv
module l0b_tag_array #(
  parameter int LINES = 8,
  parameter int IDX_W = 3,
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q[i] <= 1'b0;
      else if (sel) valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[i] <= wr_tag;
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/l0b_data_array.sv
module l0b_data_array #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [OFF_W-1:0]  lk_off,
  output logic [DATA_W-1:0] lk_word,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [LINE_W-1:0] fill_line
);
  logic [DATA_W-1:0] mem_q [LINES][WORDS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (fill_en && fill_idx == IDX_W'(i))
          mem_q[i][w] <= fill_line[w*DATA_W +: DATA_W];
        else if (wr_en && lk_idx == IDX_W'(i) && lk_off == OFF_W'(w))
          mem_q[i][w] <= wr_data;
      end
    end
  end

  assign lk_word = mem_q[lk_idx][lk_off];
endmodule

// File: rtl/l0b_ctrl.sv
module l0b_ctrl
  import l0b_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int OFF_W  = 2,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              buf_hit,
  input  logic [DATA_W-1:0] buf_word,
  output logic              buf_wr_en,
  output logic              buf_fill_en,
  output logic [ADDR_W-1:0] addr_hold,
  output logic              l1_req_valid,
  output l1_op_e            l1_op,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [DATA_W-1:0] l1_wdata,
  output logic [LINE_W-1:0] l1_wline,
  input  logic              l1_ack,
  input  logic              l1_hit,
  input  logic [LINE_W-1:0] l1_rline,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rline,
  output logic              ev_buf_hit,
  output logic              ev_l1_hit,
  output logic              ev_l1_miss
);
  state_e            state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LINE_W-1:0] line_q;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic              evb_q, evh_q, evm_q;
  logic              evb_d, evh_d, evm_d;
  logic              accept, look_done, line_en;
  logic [DATA_W-1:0] l1_word;
  logic [ADDR_W-1:0] line_addr;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign look_done = (state_q == ST_LOOK) && l1_ack;
  assign line_en   = (state_q == ST_MEM) && mem_ack;
  assign line_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    l1_word = '0;
    for (int w = 0; w < WORDS; w++)
      if (addr_q[OFF_W-1:0] == OFF_W'(w)) l1_word = l1_rline[w*DATA_W +: DATA_W];
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = req_we ? ST_WRITE : (buf_hit ? ST_IDLE : ST_LOOK);
      ST_LOOK:   if (l1_ack) state_d = l1_hit ? ST_IDLE : ST_MEM;
      ST_MEM:    if (mem_ack) state_d = ST_FILL;
      ST_FILL:   if (l1_ack) state_d = ST_REREAD;
      ST_REREAD: if (l1_ack) state_d = ST_IDLE;
      ST_WRITE:  if (l1_ack) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    evb_d       = accept && !req_we && buf_hit;
    evh_d       = look_done && l1_hit;
    evm_d       = look_done && !l1_hit;
    rsp_valid_d = evb_d || evh_d ||
                  (((state_q == ST_REREAD) || (state_q == ST_WRITE)) && l1_ack);
    rsp_data_d  = '0;
    if (evb_d)                                      rsp_data_d = buf_word;
    else if (evh_d || (state_q == ST_REREAD && l1_ack)) rsp_data_d = l1_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      evb_q       <= 1'b0;
      evh_q       <= 1'b0;
      evm_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      evb_q       <= evb_d;
      evh_q       <= evh_d;
      evm_q       <= evm_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept)      addr_q     <= req_addr;
    if (accept)      wdata_q    <= req_wdata;
    if (line_en)     line_q     <= mem_rline;
    if (rsp_valid_d) rsp_data_q <= rsp_data_d;
  end

  assign buf_wr_en     = accept && req_we && buf_hit;
  assign buf_fill_en   = evh_d;
  assign addr_hold     = addr_q;
  assign l1_req_valid  = (state_q == ST_LOOK) || (state_q == ST_FILL) ||
                         (state_q == ST_REREAD) || (state_q == ST_WRITE);
  assign l1_op         = (state_q == ST_WRITE) ? L1_OP_WR :
                         (state_q == ST_FILL)  ? L1_OP_FILL : L1_OP_RD;
  assign l1_addr       = (state_q == ST_FILL) ? line_addr : addr_q;
  assign l1_wdata      = wdata_q;
  assign l1_wline      = line_q;
  assign mem_req_valid = (state_q == ST_MEM);
  assign mem_addr      = line_addr;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_rdata     = rsp_data_q;
  assign ev_buf_hit    = evb_q;
  assign ev_l1_hit     = evh_q;
  assign ev_l1_miss    = evm_q;
endmodule

// File: rtl/l0_filter_cache.sv
module l0_filter_cache
  import l0b_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    l1_req_valid,
  output logic [1:0]              l1_op,
  output logic [ADDR_W-1:0]       l1_addr,
  output logic [DATA_W-1:0]       l1_wdata,
  output logic [DATA_W*WORDS-1:0] l1_wline,
  input  logic                    l1_ack,
  input  logic                    l1_hit,
  input  logic [DATA_W*WORDS-1:0] l1_rline,
  output logic                    mem_req_valid,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_ack,
  input  logic [DATA_W*WORDS-1:0] mem_rline,
  output logic                    ev_buf_hit,
  output logic                    ev_l1_hit,
  output logic                    ev_l1_miss
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = DATA_W * WORDS;

  logic              rst_sync_n;
  logic              buf_hit, buf_wr_en, buf_fill_en;
  logic [DATA_W-1:0] buf_word;
  logic [ADDR_W-1:0] addr_hold;
  l1_op_e            op_e;

  l0b_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  l0b_tag_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lk_idx (req_addr[OFF_W +: IDX_W]),
    .lk_tag (req_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit (buf_hit),
    .wr_en  (buf_fill_en),
    .wr_idx (addr_hold[OFF_W +: IDX_W]),
    .wr_tag (addr_hold[ADDR_W-1 -: TAG_W])
  );

  l0b_data_array #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W),
                   .OFF_W(OFF_W), .LINE_W(LINE_W)) i_data (
    .clk       (clk),
    .lk_idx    (req_addr[OFF_W +: IDX_W]),
    .lk_off    (req_addr[OFF_W-1:0]),
    .lk_word   (buf_word),
    .wr_en     (buf_wr_en),
    .wr_data   (req_wdata),
    .fill_en   (buf_fill_en),
    .fill_idx  (addr_hold[OFF_W +: IDX_W]),
    .fill_line (l1_rline)
  );

  l0b_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .OFF_W(OFF_W),
             .LINE_W(LINE_W)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_we        (req_we),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .buf_hit       (buf_hit),
    .buf_word      (buf_word),
    .buf_wr_en     (buf_wr_en),
    .buf_fill_en   (buf_fill_en),
    .addr_hold     (addr_hold),
    .l1_req_valid  (l1_req_valid),
    .l1_op         (op_e),
    .l1_addr       (l1_addr),
    .l1_wdata      (l1_wdata),
    .l1_wline      (l1_wline),
    .l1_ack        (l1_ack),
    .l1_hit        (l1_hit),
    .l1_rline      (l1_rline),
    .mem_req_valid (mem_req_valid),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack),
    .mem_rline     (mem_rline),
    .ev_buf_hit    (ev_buf_hit),
    .ev_l1_hit     (ev_l1_hit),
    .ev_l1_miss    (ev_l1_miss)
  );

  assign l1_op = op_e;
endmodule

// File: rtl/l0b_checker.sv
module l0b_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              l1_req_valid,
  input logic              l1_ack,
  input logic [1:0]        l1_op,
  input logic [ADDR_W-1:0] l1_addr,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ev_buf_hit,
  input logic              ev_l1_hit,
  input logic              ev_l1_miss
);
  AST_BUF_HIT_NO_L1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_hit |-> !l1_req_valid && $past(!l1_req_valid)); // R2

  AST_MEM_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> ev_l1_miss); // R4

  AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_addr[1:0] == 2'b00); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_req_valid || mem_req_valid) |-> !req_ready); // R7

  AST_L1_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_req_valid && !l1_ack) |=> l1_req_valid && $stable(l1_op) && $stable(l1_addr)); // R8

  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_req_valid && l1_op == 2'd2) |-> l1_addr[1:0] == 2'b00); // R8

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_buf_hit, ev_l1_hit, ev_l1_miss})); // R9
endmodule

bind l0_filter_cache l0b_checker #(.ADDR_W(ADDR_W)) i_l0b_checker (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_ready     (req_ready),
  .l1_req_valid  (l1_req_valid),
  .l1_ack        (l1_ack),
  .l1_op         (l1_op),
  .l1_addr       (l1_addr),
  .mem_req_valid (mem_req_valid),
  .mem_addr      (mem_addr),
  .ev_buf_hit    (ev_buf_hit),
  .ev_l1_hit     (ev_l1_hit),
  .ev_l1_miss    (ev_l1_miss)
);

// File: tb/test_l0_filter_cache.sv
module test_l0_filter_cache;
  localparam time CLK_PERIOD = 10ns;
  localparam int  KIND_BUF = 0, KIND_L1HIT = 1, KIND_MISS = 2;

  logic         clk, rst_n;
  logic         req_valid, req_ready, req_we;
  logic [31:0]  req_addr, req_wdata;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         l1_req_valid;
  logic [1:0]   l1_op;
  logic [31:0]  l1_addr, l1_wdata;
  logic [127:0] l1_wline, l1_rline, mem_rline;
  logic         l1_ack, l1_hit, mem_req_valid, mem_ack;
  logic [31:0]  mem_addr;
  logic         ev_buf_hit, ev_l1_hit, ev_l1_miss;

  int checks = 0, failures = 0;
  int n_l1 = 0, n_mem = 0, n_evb = 0, n_evh = 0, n_evm = 0, n_multi = 0;
  logic [1:0]  op_log [4];
  logic [31:0] fill_addr_log;
  bit done = 0;

  // bench models: cache with 32 direct-mapped lines, memory shadow
  logic         c_v   [32];
  logic [24:0]  c_tag [32];
  logic [127:0] c_line[32];
  logic [31:0]  shadow [int unsigned];

  l0_filter_cache i_l0_filter_cache (.*);

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (shadow.exists(a)) return shadow[a];
    return (a * 32'h0101_0101) ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cache responder
  initial begin
    l1_ack = 0; l1_hit = 0; l1_rline = '0;
    for (int i = 0; i < 32; i++) c_v[i] = 0;
    forever begin
      @(negedge clk);
      if (l1_ack) l1_ack = 0;
      else if (l1_req_valid) begin
        automatic int idx = int'(l1_addr[6:2]);
        automatic bit h = c_v[idx] && c_tag[idx] == l1_addr[31:7];
        op_log[n_l1 % 4] = l1_op;
        n_l1++;
        l1_hit = h;
        l1_rline = '0;
        if (l1_op == 2'd0 && h) l1_rline = c_line[idx];
        if (l1_op == 2'd1) begin
          shadow[l1_addr] = l1_wdata;
          if (h) c_line[idx][l1_addr[1:0]*32 +: 32] = l1_wdata;
        end
        if (l1_op == 2'd2) begin
          fill_addr_log = l1_addr;
          c_v[idx] = 1; c_tag[idx] = l1_addr[31:7]; c_line[idx] = l1_wline;
        end
        l1_ack = 1;
      end
    end
  end

  // memory responder
  initial begin
    mem_ack = 0; mem_rline = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req_valid) begin
        n_mem++;
        for (int w = 0; w < 4; w++) mem_rline[w*32 +: 32] = mem_word({mem_addr[31:2], 2'(w)});
        mem_ack = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (ev_buf_hit) n_evb++;
    if (ev_l1_hit)  n_evh++;
    if (ev_l1_miss) n_evm++;
    if (int'(ev_buf_hit) + int'(ev_l1_hit) + int'(ev_l1_miss) > 1) n_multi++;
  end

  // issue one request, wait for its response; returns data and latency
  task automatic issue(input bit we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int lat, output bit rdy_seen);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    lat = 1; rdy_seen = 0;
    while (!rsp_valid) begin
      if (req_ready) rdy_seen = 1;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    #1;
  endtask

  task automatic do_read(input logic [31:0] a, input int kind, input string tag);
    int l1_0, mem_0, b0, h0, m0, lat;
    logic [31:0] rd;
    bit rdy;
    l1_0 = n_l1; mem_0 = n_mem; b0 = n_evb; h0 = n_evh; m0 = n_evm;
    issue(0, a, 0, rd, lat, rdy);
    chk(rd == mem_word(a), {tag, " data"}, rd, mem_word(a));
    chk(n_evb - b0 == (kind == KIND_BUF ? 1 : 0), {tag, " ev_buf_hit"}, n_evb - b0, kind == KIND_BUF);
    chk(n_evh - h0 == (kind == KIND_L1HIT ? 1 : 0), {tag, " ev_l1_hit"}, n_evh - h0, kind == KIND_L1HIT);
    chk(n_evm - m0 == (kind == KIND_MISS ? 1 : 0), {tag, " ev_l1_miss"}, n_evm - m0, kind == KIND_MISS);
    chk(n_l1 - l1_0 == (kind == KIND_BUF ? 0 : kind == KIND_L1HIT ? 1 : 3),
        {tag, " cache accesses"}, n_l1 - l1_0, kind == KIND_BUF ? 0 : kind == KIND_L1HIT ? 1 : 3);
    chk(n_mem - mem_0 == (kind == KIND_MISS ? 1 : 0), {tag, " memory fetches"}, n_mem - mem_0, kind == KIND_MISS);
    if (kind == KIND_BUF) chk(lat == 1, {tag, " R2 latency"}, lat, 1);
    else chk(!rdy, {tag, " R7 ready low while busy"}, rdy, 0);
    if (kind == KIND_MISS) begin
      chk(op_log[(n_l1-3)%4] == 2'd0 && op_log[(n_l1-2)%4] == 2'd2 && op_log[(n_l1-1)%4] == 2'd0,
          "R8 op sequence read,fill,read", {op_log[(n_l1-3)%4], op_log[(n_l1-2)%4], op_log[(n_l1-1)%4]}, 6'b00_10_00);
      chk(fill_addr_log == {a[31:2], 2'b00}, "R8 fill address aligned", fill_addr_log, {a[31:2], 2'b00});
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d);
    int l1_0, e0, lat;
    logic [31:0] rd;
    bit rdy;
    l1_0 = n_l1; e0 = n_evb + n_evh + n_evm;
    issue(1, a, d, rd, lat, rdy);
    chk(n_l1 - l1_0 == 1 && op_log[(n_l1-1)%4] == 2'd1, "R6 single cache word write", op_log[(n_l1-1)%4], 1);
    chk(!rdy, "R7 ready low during write", rdy, 0);
    chk(n_evb + n_evh + n_evm == e0, "R6 write raises no read event", n_evb + n_evh + n_evm - e0, 0);
    chk(shadow.exists(a) && shadow[a] == d, "R6 write reached cache port", mem_word(a), d);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);
    chk({ev_buf_hit, ev_l1_hit, ev_l1_miss} == 0, "R1 no events after reset", {ev_buf_hit, ev_l1_hit, ev_l1_miss}, 0);
  endtask

  task automatic t_fill_filter();
    do_read(32'h0000_1004, KIND_MISS,  "R1 R4 cold read misses everywhere");
    do_read(32'h0000_1004, KIND_L1HIT, "R4 buffer unchanged after miss, R3 cache hit");
    do_read(32'h0000_1005, KIND_BUF,   "R3 line allocated");
    do_read(32'h0000_1007, KIND_BUF,   "R2 last word of line");
  endtask

  task automatic t_replace();
    do_read(32'h0000_1024, KIND_MISS,  "R4 conflicting line miss");
    do_read(32'h0000_1024, KIND_L1HIT, "R3 conflicting line cache hit");
    do_read(32'h0000_1026, KIND_BUF,   "R5 new line now buffered");
    do_read(32'h0000_1004, KIND_L1HIT, "R5 displaced line misses buffer");
  endtask

  task automatic t_write();
    do_write(32'h0000_1006, 32'hDEAD_BEEF);
    do_read(32'h0000_1006, KIND_BUF, "R6 buffered copy updated");
    do_write(32'h0000_2010, 32'h1234_5678);
    do_read(32'h0000_2010, KIND_MISS, "R6 write allocates nothing");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_filter();
    t_replace();
    t_write();
    chk(n_multi == 0, "R9 events exclusive", n_multi, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule